// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns characters written into a single holding register into asynchronous serial frames on one output line. Each frame begins with a low start bit, carries 7, 8 or 9 data bits least-significant first, and may add a parity bit. It ends with one or two high stop bits. The bit period is set by a coarse clock prescaler and an 8-bit divider. The line rests high between frames.

Software writes a character whenever the holding register is empty. The character moves into the shift stage as soon as the transmitter is enabled and no frame is in flight. When the clear-to-send check is switched on, the peer's active-low clear-to-send signal must also be asserted. The peer signal is synchronized and looked at only when a new frame is about to start. A one-cycle interrupt pulse marks either the hand-over of a character to the shift stage or the end of its last stop bit. An active-low ready output tells the peer or software that another character can be taken.

Top module: `uart_tx_flow`

## Requirements
- R1: A frame starts with one low start bit, followed by the data bits least-significant bit first; `char_len` 0 selects 7 bits, 2 selects 9 bits, and 1 or 3 selects 8 bits (wr_data bits above the length are not sent).
- R2: `parity_mode` 2 appends an even parity bit and 3 appends an odd one, each covering only the configured data bits (even makes the total count of ones over data plus parity even, odd makes it odd); 0 or 1 sends no parity bit.
- R3: After data and parity come one high stop bit, or two when `two_stop` is 1; `txd` is high whenever no frame is in flight and after reset.
- R4: Every bit lasts D x 16 x (divider + 1) clock cycles, where D is 1 for `clk_sel` 0, 8 for 1 and 32 for 2 or 3.
- R5: A frame starts only while `tx_enable` is 1 and the holding register is full (`buf_empty` 0); with both true and the line idle, `txd` goes low on the second rising edge after the write edge.
- R6: With `cts_enable` 1, a frame starts only after `cts_n` has been low at two consecutive rising edges (two-stage synchronizer), so `txd` falls on the third edge after `cts_n` drops; with `cts_enable` 0, `cts_n` has no effect.
- R7: `cts_n` changing during a frame does not alter or stop that frame.
- R8: A write while a frame is in flight is held; `buf_empty` stays 0 until the frame's last stop bit ends, then the held character starts one cycle later and `buf_empty` returns to 1 at that hand-over.
- R9: With `irq_on_done` 0, `tx_irq` pulses for one cycle right after a character is handed to the shift stage; with 1, it pulses for one cycle right after the last stop bit ends.
- R10: `ready_n` is low exactly when `tx_enable` is 1 and the holding register is empty.
- R11: After reset `txd` is 1, `buf_empty` is 1 and `tx_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Prescaler select: 0 = /1, 1 = /8, 2 or 3 = /32 |
| divider | input | 8 | Bit-rate divider n; bit period 16 x (n+1) prescaled clocks |
| char_len | input | 2 | Data length: 0 = 7, 1 or 3 = 8, 2 = 9 bits |
| parity_mode | input | 2 | 0/1 none, 2 even, 3 odd |
| two_stop | input | 1 | 1 selects two stop bits |
| tx_enable | input | 1 | Allows frames to start |
| cts_enable | input | 1 | 1 makes frame start wait for cts_n low |
| cts_n | input | 1 | Active-low clear-to-send from the peer |
| irq_on_done | input | 1 | Interrupt cause: 0 hand-over, 1 frame end |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to hold |
| txd | output | 1 | Serial output line |
| ready_n | output | 1 | Low when enabled and the holding register is empty |
| buf_empty | output | 1 | Holding register is empty |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
Frames are compared bit by bit on every cycle against a frame built arithmetically in the bench. All eighteen combinations of length, parity and stop count are run with alternating-bit and single-high-bit characters. Alternating patterns show whether bits are sent in the right order. The single ninth-bit pattern shows whether the length setting is applied and whether parity covers only the sent bits. A sweep over every prescaler setting and several divider values checks the bit-period arithmetic. Separate sequences hold the transmitter off through the enable and through clear-to-send, drop clear-to-send in mid-frame, and write during a frame. These show the start gating, the synchronizer latency, the once-per-frame sampling and the hand-over timing.

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int DIV_W    = 8,
  parameter int OVS_LOG2 = 4,
  parameter int DATA_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        clk_sel,
  input  logic [DIV_W-1:0]  divider,
  input  logic [1:0]        char_len,
  input  logic [1:0]        parity_mode,
  input  logic              two_stop,
  input  logic              tx_enable,
  input  logic              cts_enable,
  input  logic              cts_n,
  input  logic              irq_on_done,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              ready_n,
  output logic              buf_empty,
  output logic              tx_irq
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = DIV_W + OVS_LOG2;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [1:0]          cts_sync;
  logic                busy;
  logic [DATA_W-1:0]   hold;
  logic [FRAME_W-1:0]  frame, load_frame;
  logic [LEFT_W-1:0]   bits_left, load_bits;
  logic [4:0]          pre_cnt, pre_last;
  logic [CNT_W-1:0]    bit_cnt;
  logic [LEFT_W-1:0]   len;
  logic                par;

  assign pre_last = (clk_sel == 2'd0) ? 5'd0 : (clk_sel == 2'd1) ? 5'd7 : 5'd31;

  wire tick    = pre_cnt == pre_last;
  wire bit_end = busy && tick && (bit_cnt == {divider, {OVS_LOG2{1'b1}}});
  wire cts_ok  = !cts_enable || !cts_sync[1];
  wire start   = !busy && tx_enable && !buf_empty && cts_ok;

  assign txd     = frame[0];
  assign ready_n = !(tx_enable && buf_empty);

  always_comb begin
    case (char_len)
      2'd0:    len = LEFT_W'(DATA_W - 2);
      2'd2:    len = LEFT_W'(DATA_W);
      default: len = LEFT_W'(DATA_W - 1);
    endcase
    load_frame    = '1;
    load_frame[0] = 1'b0;
    par           = parity_mode[0];
    for (int i = 0; i < DATA_W; i++) begin
      if (LEFT_W'(i) < len) begin
        load_frame[i+1] = hold[i];
        par             = par ^ hold[i];
      end
    end
    if (parity_mode[1]) load_frame[len+1] = par;
    load_bits = len + LEFT_W'(parity_mode[1]) + LEFT_W'(two_stop) + LEFT_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_sync  <= 2'b11;
      busy      <= 1'b0;
      hold      <= '0;
      buf_empty <= 1'b1;
      frame     <= '1;
      bits_left <= '0;
      pre_cnt   <= '0;
      bit_cnt   <= '0;
      tx_irq    <= 1'b0;
    end else begin
      cts_sync <= {cts_sync[0], cts_n};
      tx_irq   <= 1'b0;
      if (start) begin
        frame     <= load_frame;
        bits_left <= load_bits;
        busy      <= 1'b1;
        pre_cnt   <= '0;
        bit_cnt   <= '0;
        buf_empty <= 1'b1;
        tx_irq    <= !irq_on_done;
      end else if (busy) begin
        pre_cnt <= tick ? '0 : pre_cnt + 5'd1;
        if (tick) bit_cnt <= bit_end ? '0 : bit_cnt + CNT_W'(1);
        if (bit_end) begin
          frame     <= {1'b1, frame[FRAME_W-1:1]};
          bits_left <= bits_left - LEFT_W'(1);
          if (bits_left == LEFT_W'(1)) begin
            busy   <= 1'b0;
            tx_irq <= irq_on_done;
          end
        end
      end
      if (wr_en) begin
        hold      <= wr_data;
        buf_empty <= 1'b0;
      end
    end
  end

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_start_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> ($past(tx_enable) && !$past(buf_empty)));

  assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && $past(cts_enable)) |-> !$past(cts_sync[1]));

  assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_end)) |-> $stable(txd));

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  assert_empty_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $rose(busy));
endmodule

// File: tb/sim_uart_tx_flow.sv
module sim_uart_tx_flow;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] divider = 8'd0;
  logic [1:0] char_len = 2'd1;
  logic [1:0] parity_mode = 2'd0;
  logic two_stop = 1'b0;
  logic tx_enable = 1'b1;
  logic cts_enable = 1'b0;
  logic cts_n = 1'b1;
  logic irq_on_done = 1'b0;
  logic wr_en = 1'b0;
  logic [8:0] wr_data = 9'd0;
  logic txd, ready_n, buf_empty, tx_irq;

  int pass_cnt = 0;
  int fail_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_tx_flow u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .divider(divider),
    .char_len(char_len), .parity_mode(parity_mode), .two_stop(two_stop),
    .tx_enable(tx_enable), .cts_enable(cts_enable), .cts_n(cts_n),
    .irq_on_done(irq_on_done), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .ready_n(ready_n), .buf_empty(buf_empty), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    if (act == exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int n_len();
    return (char_len == 2'd0) ? 7 : (char_len == 2'd2) ? 9 : 8;
  endfunction

  function automatic int n_bits();
    return 1 + n_len() + int'(parity_mode[1]) + 1 + int'(two_stop);
  endfunction

  function automatic int bit_period();
    int d;
    d = (clk_sel == 2'd0) ? 1 : (clk_sel == 2'd1) ? 8 : 32;
    return d * 16 * (int'(divider) + 1);
  endfunction

  function automatic logic exp_bit(input int b, input logic [8:0] d);
    int ones;
    ones = 0;
    if (b == 0) return 1'b0;
    if (b <= n_len()) return d[b-1];
    if (b == n_len() + 1 && parity_mode[1]) begin
      for (int i = 0; i < n_len(); i++) ones += int'(d[i]);
      return parity_mode[0] ? ((ones % 2) == 0) : ((ones % 2) == 1);
    end
    return 1'b1;
  endfunction

  task automatic write_char(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Called at the negedge right after the load edge; returns at the negedge after the frame end.
  task automatic observe(input logic [8:0] d, input string req);
    int p, n, bad, first_j, exp_i;
    logic e;
    p = bit_period();
    n = n_bits();
    bad = 0;
    first_j = -1;
    for (int j = 0; j <= n * p; j++) begin
      if (j > 0) @(negedge clk);
      e = (j / p < n) ? exp_bit(j / p, d) : 1'b1;
      exp_i = irq_on_done ? int'(j == n * p) : int'(j == 0);
      if (txd !== e || tx_irq !== exp_i[0]) begin
        bad++;
        if (first_j < 0) first_j = j;
      end
    end
    chk(req, $sformatf("frame d=%0h len=%0d par=%0d stop2=%0d p=%0d bad cycles (first at %0d)",
        d, n_len(), parity_mode, two_stop, p, first_j), bad, 0);
  endtask

  task automatic send(input logic [8:0] d, input string req);
    write_char(d);
    chk("R5", "txd before load", int'(txd), 1);
    chk("R8", "buf_empty after write", int'(buf_empty), 0);
    @(negedge clk);
    observe(d, req);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fail_cnt++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

  initial begin
    logic [8:0] pats [3];
    int idle_bad;
    pats[0] = 9'h155; pats[1] = 9'h0AA; pats[2] = 9'h100;

    repeat (3) @(negedge clk);
    chk("R11", "txd in reset", int'(txd), 1);
    chk("R11", "buf_empty in reset", int'(buf_empty), 1);
    chk("R11", "tx_irq in reset", int'(tx_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "ready_n enabled and empty", int'(ready_n), 0);

    // R1 R2 R3 format sweep; cts_n held high while cts_enable is 0 (R6 ignore)
    for (int cl = 0; cl < 3; cl++)
      for (int pm = 0; pm < 4; pm++) begin
        if (pm == 1) continue;
        for (int ts = 0; ts < 2; ts++)
          for (int k = 0; k < 3; k++) begin
            char_len = 2'(cl); parity_mode = 2'(pm); two_stop = ts[0];
            irq_on_done = k[0];
            send(pats[k], "R1 R2 R3 R6 R9");
          end
      end
    char_len = 2'd3; parity_mode = 2'd1; two_stop = 1'b0;
    send(9'h1C3, "R1 R2");

    // R4 prescaler and divider sweep
    char_len = 2'd1; parity_mode = 2'd3; irq_on_done = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int dv = 0; dv < 3; dv++) begin
        if (s == 3 && dv > 0) continue;
        clk_sel = 2'(s); divider = 8'(dv);
        send(9'h0C5, "R4");
      end
    clk_sel = 2'd0; divider = 8'd0;

    // R5 / R10 transmit enable gating
    tx_enable = 1'b0;
    irq_on_done = 1'b0;
    write_char(9'h03C);
    idle_bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) idle_bad++;
    end
    chk("R5", "txd held while disabled", idle_bad, 0);
    chk("R10", "ready_n while disabled", int'(ready_n), 1);
    tx_enable = 1'b1;
    chk("R10", "ready_n enabled but full", int'(ready_n), 1);
    @(negedge clk);
    observe(9'h03C, "R5");
    chk("R10", "ready_n after frame", int'(ready_n), 0);
    repeat (3) @(negedge clk);

    // R6 / R7 clear-to-send gating and mid-frame change
    cts_enable = 1'b1;
    cts_n = 1'b1;
    write_char(9'h0E1);
    idle_bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) idle_bad++;
    end
    chk("R6", "txd held while cts_n high", idle_bad, 0);
    cts_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6", "txd one edge before sync done", int'(txd), 1);
    @(negedge clk);
    fork
      observe(9'h0E1, "R7");
      begin
        repeat (30) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    write_char(9'h01F);
    idle_bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) idle_bad++;
    end
    chk("R6", "txd held after cts_n rise", idle_bad, 0);
    cts_enable = 1'b0;
    @(negedge clk);
    observe(9'h01F, "R6");
    repeat (3) @(negedge clk);

    // R8 write during a frame, with hand-over interrupt (R9)
    irq_on_done = 1'b0;
    write_char(9'h0A3);
    @(negedge clk);
    fork
      observe(9'h0A3, "R8");
      begin
        repeat (20) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 9'h05C;
        @(negedge clk);
        wr_en = 1'b0;
      end
    join
    chk("R8", "buf_empty at frame end", int'(buf_empty), 0);
    @(negedge clk);
    chk("R8", "buf_empty after hand-over", int'(buf_empty), 1);
    observe(9'h05C, "R8 R9");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  %0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule